// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns characters taken from a transmit queue into asynchronous serial frames on a single line. Before each character it looks at the format controls: a two-bit code for the number of data bits, a parity on/off control, a parity-sense control, a stuck-parity control and a one/two stop-bit control. It then sends a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. Each bit lasts sixteen pulses of a free-running baud tick that runs at sixteen times the bit rate.

A character is taken from the queue by a one-cycle pop strobe. The strobe fires only when the queue offers a character, the transmitter is idle, both the global enable and the transmit enable are set, no break is requested, and, when flow control is on, CTS is asserted. A break request holds the line low once the character on the line has finished. Dropping an enable in the middle of a character lets that character finish. The busy output covers both the line and the queue.

Top module: `uart_frame_tx`

## Requirements
- R1: The word-length code `wordLen` selects 5 data bits for 00, 6 for 01, 7 for 10 and 8 for 11. Data bits go out least significant bit first. Every bit of a frame lasts exactly 16 `baudTick` pulses.
- R2: A frame is, in this order: one low start bit, the data bits, a parity bit only when `parityEn` is 1, and then the stop bits, which are high.
- R3: With `parityEn`=1 and `stickParity`=0, `paritySel`=1 makes the data bits plus the parity bit hold an even number of ones, and `paritySel`=0 makes it an odd number.
- R4: With `parityEn`=1 and `stickParity`=1, the parity bit is always 1 when `paritySel`=0 and always 0 when `paritySel`=1, whatever the data.
- R5: `twoStop`=1 ends a frame with two stop bits, and `twoStop`=0 ends it with one.
- R6: While `sendBreak` is 1, `txd` is held low without a gap, starting right after the last stop bit of the character in progress. No character is popped while the break is held. When the break is released, the line returns high.
- R7: Clearing `enGlobal` or `enTx` during a character does not shorten or alter that character. While either enable is 0, no new character is popped.
- R8: `busy` is 1 whenever `chrValid` is 1, even with the transmitter disabled. It is also 1 from the start bit until the last stop bit has finished. Otherwise it is 0.
- R9: With `ctsFlowEn`=1, a character is popped only while `ctsIn` is 1. With `ctsFlowEn`=0, `ctsIn` is ignored.
- R10: The format controls are captured when a character is popped. Changing them during the frame leaves that frame unchanged.
- R11: During and right after reset, `txd` is 1, `busy` is 0 and `chrPop` is 0.
- R12: `chrPop` is a one-cycle strobe. It is raised only while `chrValid` is 1, and the start bit appears on `txd` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudTick | input | 1 | One-cycle pulse at 16x the bit rate |
| chrValid | input | 1 | Queue holds a character |
| chrData | input | 8 | Character at the head of the queue |
| chrPop | output | 1 | Takes the head character from the queue this cycle |
| enGlobal | input | 1 | Global enable |
| enTx | input | 1 | Transmit enable |
| wordLen | input | 2 | Data-bit count code (00=5 ... 11=8) |
| parityEn | input | 1 | Adds a parity bit |
| paritySel | input | 1 | 1 = even, 0 = odd parity |
| stickParity | input | 1 | Fixes the parity bit to the inverse of paritySel |
| twoStop | input | 1 | Two stop bits |
| sendBreak | input | 1 | Hold the line low after the current character |
| ctsFlowEn | input | 1 | Gate character starts on CTS |
| ctsIn | input | 1 | CTS, active high |
| txd | output | 1 | Serial output, idles high |
| busy | output | 1 | Line or queue busy |

## Verification
Two pairs of events can land on the same clock edge. The first pair is the final tick of the last stop bit and a queue that already offers the next character while a break is requested. The bench provokes this by raising `sendBreak` and `chrValid` together during the data bits. It then expects `txd` low on the very next sample and no pop, and it expects `busy` to stay high for the waiting character. The second pair is an enable drop and an ongoing frame. Enables and format controls are changed in mid-frame, and every sample of that frame is still compared against the bit sequence computed from the settings in force when the character was popped.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2,
    ST_BREAK
  } txState_e;

  typedef enum logic [1:0] {
    LINE_MARK,
    LINE_SPACE,
    LINE_DATA,
    LINE_PARITY
  } lineSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     shift;
    lineSel_e lineSel;
  } dpCtrl_t;

endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8,
  parameter int MIN_BITS      = 5,
  localparam int WL_W         = $clog2(DATA_W - MIN_BITS + 1),
  localparam int TCNT_W       = $clog2(TICKS_PER_BIT),
  localparam int BCNT_W       = $clog2(DATA_W)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            baudTick,
  input  logic            chrValid,
  input  logic            enGlobal,
  input  logic            enTx,
  input  logic            sendBreak,
  input  logic            ctsFlowEn,
  input  logic            ctsIn,
  input  logic [WL_W-1:0] wordLen,
  input  logic            parityEn,
  input  logic            twoStop,
  output logic            chrPop,
  output logic            busy,
  output dpCtrl_t         dpCtrl
);

  txState_e          stateQ, stateD;
  logic [TCNT_W-1:0] tickCntQ;
  logic [BCNT_W-1:0] bitCntQ, lastBitQ;
  logic              parEnQ, twoStopQ;
  logic              startOk, bitEnd, inFrame;

  assign inFrame = (stateQ != ST_IDLE) && (stateQ != ST_BREAK);
  assign bitEnd  = baudTick && (tickCntQ == TCNT_W'(TICKS_PER_BIT - 1));
  assign startOk = (stateQ == ST_IDLE) && chrValid && enGlobal && enTx &&
                   !sendBreak && (!ctsFlowEn || ctsIn);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (sendBreak) stateD = ST_BREAK;
                 else if (startOk) stateD = ST_START;
      ST_START:  if (bitEnd) stateD = ST_DATA;
      ST_DATA:   if (bitEnd && bitCntQ == lastBitQ)
                   stateD = parEnQ ? ST_PARITY : ST_STOP1;
      ST_PARITY: if (bitEnd) stateD = ST_STOP1;
      ST_STOP1:  if (bitEnd) stateD = twoStopQ ? ST_STOP2 :
                                      (sendBreak ? ST_BREAK : ST_IDLE);
      ST_STOP2:  if (bitEnd) stateD = sendBreak ? ST_BREAK : ST_IDLE;
      ST_BREAK:  if (!sendBreak) stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      tickCntQ <= '0;
      bitCntQ  <= '0;
      lastBitQ <= '0;
      parEnQ   <= 1'b0;
      twoStopQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (!inFrame) tickCntQ <= '0;
      else if (baudTick) tickCntQ <= bitEnd ? '0 : tickCntQ + 1'b1;
      if (startOk) begin
        bitCntQ  <= '0;
        lastBitQ <= BCNT_W'(MIN_BITS - 1) + BCNT_W'(wordLen);
        parEnQ   <= parityEn;
        twoStopQ <= twoStop;
      end else if (stateQ == ST_DATA && bitEnd) begin
        bitCntQ <= bitCntQ + 1'b1;
      end
    end
  end

  always_comb begin
    dpCtrl.load  = startOk;
    dpCtrl.shift = (stateQ == ST_DATA) && bitEnd;
    unique case (stateQ)
      ST_START, ST_BREAK: dpCtrl.lineSel = LINE_SPACE;
      ST_DATA:            dpCtrl.lineSel = LINE_DATA;
      ST_PARITY:          dpCtrl.lineSel = LINE_PARITY;
      default:            dpCtrl.lineSel = LINE_MARK;
    endcase
  end

  assign chrPop = startOk;
  assign busy   = chrValid || inFrame;

endmodule

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  localparam int WL_W    = $clog2(DATA_W - MIN_BITS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [DATA_W-1:0] chrData,
  input  logic [WL_W-1:0]   wordLen,
  input  logic              paritySel,
  input  logic              stickParity,
  output logic              txd
);

  logic [DATA_W-1:0] shiftQ, wordMask;
  logic              parBitQ, parCalc;

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      wordMask[i] = (i < MIN_BITS + int'(wordLen));
  end

  // even sense: parity = xor of data; odd sense: its inverse; stuck: ~paritySel
  assign parCalc = stickParity ? ~paritySel
                               : (paritySel ? ^(chrData & wordMask)
                                            : ~^(chrData & wordMask));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      parBitQ <= 1'b0;
    end else if (dpCtrl.load) begin
      shiftQ  <= chrData;
      parBitQ <= parCalc;
    end else if (dpCtrl.shift) begin
      shiftQ <= shiftQ >> 1;
    end
  end

  always_comb begin
    unique case (dpCtrl.lineSel)
      LINE_SPACE:  txd = 1'b0;
      LINE_DATA:   txd = shiftQ[0];
      LINE_PARITY: txd = parBitQ;
      default:     txd = 1'b1;
    endcase
  end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8,
  parameter int MIN_BITS      = 5,
  localparam int WL_W         = $clog2(DATA_W - MIN_BITS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              chrValid,
  input  logic [DATA_W-1:0] chrData,
  output logic              chrPop,
  input  logic              enGlobal,
  input  logic              enTx,
  input  logic [WL_W-1:0]   wordLen,
  input  logic              parityEn,
  input  logic              paritySel,
  input  logic              stickParity,
  input  logic              twoStop,
  input  logic              sendBreak,
  input  logic              ctsFlowEn,
  input  logic              ctsIn,
  output logic              txd,
  output logic              busy
);

  dpCtrl_t dpCtrl;

  uart_tx_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT), .DATA_W(DATA_W), .MIN_BITS(MIN_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .chrValid(chrValid),
    .enGlobal(enGlobal), .enTx(enTx), .sendBreak(sendBreak),
    .ctsFlowEn(ctsFlowEn), .ctsIn(ctsIn), .wordLen(wordLen),
    .parityEn(parityEn), .twoStop(twoStop), .chrPop(chrPop), .busy(busy),
    .dpCtrl(dpCtrl)
  );

  uart_tx_datapath #(
    .DATA_W(DATA_W), .MIN_BITS(MIN_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .chrData(chrData),
    .wordLen(wordLen), .paritySel(paritySel), .stickParity(stickParity),
    .txd(txd)
  );

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rstN,
  input logic chrValid,
  input logic chrPop,
  input logic enGlobal,
  input logic enTx,
  input logic sendBreak,
  input logic ctsFlowEn,
  input logic ctsIn,
  input logic txd,
  input logic busy
);

  assert_pop_needs_valid_R12: assert property (@(posedge clk) disable iff (!rstN)
    chrPop |-> chrValid);

  assert_start_after_pop_R12: assert property (@(posedge clk) disable iff (!rstN)
    chrPop |=> !txd);

  assert_pop_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    chrPop |=> !chrPop);

  assert_busy_on_queue_R8: assert property (@(posedge clk) disable iff (!rstN)
    chrValid |-> busy);

  assert_no_pop_in_break_R6: assert property (@(posedge clk) disable iff (!rstN)
    sendBreak |-> !chrPop);

  assert_no_pop_disabled_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(enGlobal && enTx) |-> !chrPop);

  assert_cts_gates_pop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctsFlowEn && !ctsIn) |-> !chrPop);

endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .chrValid(chrValid), .chrPop(chrPop),
  .enGlobal(enGlobal), .enTx(enTx), .sendBreak(sendBreak),
  .ctsFlowEn(ctsFlowEn), .ctsIn(ctsIn), .txd(txd), .busy(busy)
);

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       chrValid = 1'b0;
  logic [7:0] chrData = '0;
  logic       chrPop;
  logic       enGlobal = 1'b1, enTx = 1'b1;
  logic [1:0] wordLen = 2'b11;
  logic       parityEn = 1'b0, paritySel = 1'b0, stickParity = 1'b0;
  logic       twoStop = 1'b0, sendBreak = 1'b0;
  logic       ctsFlowEn = 1'b0, ctsIn = 1'b0;
  logic       txd, busy;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  uart_frame_tx u0 (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .chrValid(chrValid),
    .chrData(chrData), .chrPop(chrPop), .enGlobal(enGlobal), .enTx(enTx),
    .wordLen(wordLen), .parityEn(parityEn), .paritySel(paritySel),
    .stickParity(stickParity), .twoStop(twoStop), .sendBreak(sendBreak),
    .ctsFlowEn(ctsFlowEn), .ctsIn(ctsIn), .txd(txd), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
      finishRun();
    end
  end

  task automatic tickBit();
    baudTick = 1'b1;
    @(negedge clk);
    baudTick = 1'b0;
    @(negedge clk);
  endtask

  // mode: 0 plain, 1 change format mid-frame (R10), 2 disable mid-frame (R7),
  //       3 break plus waiting character mid-frame (R6)
  task automatic runFrame(input logic [7:0] d, input logic [1:0] wl, input logic pe,
                          input logic ps, input logic sp, input logic ts, input int mode);
    logic exp [12];
    int   nb, nBits, ones;
    logic par;
    wordLen = wl; parityEn = pe; paritySel = ps; stickParity = sp; twoStop = ts;
    enGlobal = 1'b1; enTx = 1'b1; sendBreak = 1'b0;
    chrData = d; chrValid = 1'b1;
    #1;
    check(chrPop === 1'b1, "R12 pop", chrPop, 1);
    @(negedge clk);
    chrValid = 1'b0;
    nBits = 5 + int'(wl);
    ones = 0;
    nb = 0;
    exp[nb++] = 1'b0;
    for (int i = 0; i < nBits; i++) begin
      exp[nb++] = d[i];
      ones += int'(d[i]);
    end
    if (pe) begin
      if (sp) par = ~ps;
      else par = ps ? logic'(ones % 2) : logic'((ones + 1) % 2);
      exp[nb++] = par;
    end
    exp[nb++] = 1'b1;
    if (ts) exp[nb++] = 1'b1;
    for (int b = 0; b < nb; b++) begin
      for (int t = 0; t < 16; t++) begin
        if (b == 2 && t == 0) begin
          if (mode == 1) begin
            wordLen = ~wl; parityEn = ~pe; paritySel = ~ps;
            stickParity = ~sp; twoStop = ~ts; chrData = ~d;
          end else if (mode == 2) begin
            enGlobal = 1'b0; enTx = 1'b0; chrValid = 1'b1;
          end else if (mode == 3) begin
            sendBreak = 1'b1; chrValid = 1'b1; chrData = 8'h3C;
          end
        end
        check(txd === exp[b], "R1 R2 R3 R4 R5 R10 bit", txd, exp[b]);
        check(busy === 1'b1, "R8 busy in frame", busy, 1);
        if (mode != 0) check(chrPop === 1'b0, "R6 R7 no pop in frame", chrPop, 0);
        tickBit();
      end
    end
    check(txd === (mode == 3 ? 1'b0 : 1'b1), "R6 line after frame", txd, mode == 3 ? 0 : 1);
    check(busy === (mode >= 2), "R8 busy after frame", busy, mode >= 2 ? 1 : 0);
    if (mode >= 2) begin
      for (int k = 0; k < 40; k++) begin
        check(chrPop === 1'b0, "R6 R7 held off", chrPop, 0);
        check(txd === (mode == 3 ? 1'b0 : 1'b1), "R6 break held", txd, mode == 3 ? 0 : 1);
        if (k % 2 == 0) tickBit(); else @(negedge clk);
      end
      chrValid = 1'b0; sendBreak = 1'b0; enGlobal = 1'b1; enTx = 1'b1;
      @(negedge clk);
      check(txd === 1'b1, "R6 break release", txd, 1);
      check(busy === 1'b0, "R8 idle", busy, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(txd === 1'b1, "R11 txd in reset", txd, 1);
    check(busy === 1'b0, "R11 busy in reset", busy, 0);
    check(chrPop === 1'b0, "R11 pop in reset", chrPop, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(txd === 1'b1 && busy === 1'b0, "R11 after reset", {txd, busy}, 2);

    // sweep of all formats
    for (int wl = 0; wl < 4; wl++)
      for (int pm = 0; pm < 5; pm++)
        for (int ts = 0; ts < 2; ts++)
          runFrame(8'hA5 ^ 8'(wl * 37 + pm * 11 + ts * 91), 2'(wl), pm != 0,
                   pm == 2 || pm == 4, pm >= 3, 1'(ts), 0);
    runFrame(8'h00, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    runFrame(8'hFF, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 0);

    // R10 format change mid-frame
    runFrame(8'h5A, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1);
    runFrame(8'hC3, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1);
    // R7 disable mid-frame
    runFrame(8'h96, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 2);
    // R6 break mid-frame with waiting character
    runFrame(8'h69, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 3);

    // R8 busy while disabled, R7 no pop
    enTx = 1'b0; chrValid = 1'b1; chrData = 8'h11;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(busy === 1'b1, "R8 busy when disabled", busy, 1);
      check(chrPop === 1'b0, "R7 no pop when disabled", chrPop, 0);
    end
    chrValid = 1'b0; enTx = 1'b1;

    // R9 flow control
    ctsFlowEn = 1'b1; ctsIn = 1'b0; chrValid = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(chrPop === 1'b0, "R9 blocked by cts", chrPop, 0);
      check(txd === 1'b1, "R9 line idle", txd, 1);
    end
    ctsIn = 1'b1;
    runFrame(8'h4E, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    ctsFlowEn = 1'b0; ctsIn = 1'b0;
    runFrame(8'hB1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 0);  // R9 cts ignored

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule